// File: doc/BRIEF.md
# Synchronous Late-Write Static Memory

This block is a single-port synchronous memory whose write data trails its command by one clock. On each rising edge it samples the select, the write enable, the address and the per-lane write enables. When that command is a write, the data word for it is sampled on the following rising edge. The data then sits in a late-write buffer, which is written into the storage array on the edge after that. A read command returns its word from an output register one cycle after the command edge. Any lanes held in the buffer for the same address are merged into that word, so a read never returns stale data.

The word is split into 9-bit lanes. The default build has four lanes (36 bits). A build with two lanes gives 18 bits. `ADDR_W` sets the depth, for example 15 address bits for the 36-bit form or 16 for the 18-bit form. The output enable acts without a clock. While it is low, the read bus is driven to all zeros. When it goes high again, the held word shows.

Top module: `lw_sram`

## Requirements
- R1: After reset, with `oe` high, `rdata` is all zeros and no write is pending.
- R2: `sel`, `we`, `addr` and `bw` are sampled on a rising edge. For a write command (`sel`=1, `we`=1) the data word is the value of `wdata` at the next rising edge, whatever the command inputs are at that edge.
- R3: A read command (`sel`=1, `we`=0) sampled at edge N puts the addressed word on `rdata` after edge N+1.
- R4: Lane i is bits [9i+8:9i]. `bw[i]`=1 writes lane i, and a lane whose `bw` bit is 0 keeps its old content. An all-zero `bw` writes nothing.
- R5: A read issued in the cycle right after a write to the same address returns that write's lanes merged over the stored word.
- R6: Back-to-back writes to one address with different lane masks accumulate, and a later read shows all written lanes.
- R7: A read followed by a write to the same address returns the word as it was before that write.
- R8: A cycle with `sel`=0 starts no access, but a write issued in the previous cycle still completes with the `wdata` sampled in the deselected cycle.
- R9: Through write and deselect cycles, `rdata` keeps the last word read.
- R10: While `oe` is low, `rdata` is all zeros at once, with no clock edge needed. When `oe` returns high, the held word appears again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Synchronous select; 0 makes the cycle a deselect |
| we | input | 1 | 1 = write command, 0 = read command |
| addr | input | ADDR_W | Word address |
| bw | input | LANES | Per-lane write enables for the command |
| wdata | input | 9*LANES | Data for the write command of the previous cycle |
| oe | input | 1 | Asynchronous output enable; low forces `rdata` to zero |
| rdata | output | 9*LANES | Read word from the output register, gated by `oe` |

## Verification
The bench drives dense traffic over a handful of addresses so that reads often land on a word whose write is still in the buffer. A design that skipped forwarding would return the stored word from before the write in that case. Write-write pairs to one address use disjoint and overlapping lane masks. A design that wrote whole words, or dropped the first write, would lose lanes. The bench puts deselects and all-zero masks between a write and its data. This exposes a design that tied commitment to the select or ignored the mask. It also toggles `oe` between edges, which catches a design that registered the output enable.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W    = 9;
  localparam int MAX_LANES = 4;
  localparam int MAX_W     = LANE_W * MAX_LANES;

  // Overlay enabled lanes of upd onto base.
  function automatic logic [MAX_W-1:0] lane_merge(
    input logic [MAX_W-1:0]     base,
    input logic [MAX_W-1:0]     upd,
    input logic [MAX_LANES-1:0] en
  );
    logic [MAX_W-1:0] r;
    r = base;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (en[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/lw_cmd_reg.sv
module lw_cmd_reg #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw,
  output logic              s1_rd,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rd   <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_mask <= '0;
    end else begin
      s1_rd   <= sel & ~we;
      s1_wr   <= sel & we;
      s1_addr <= addr;
      s1_mask <= bw;
    end
  end

  // R8
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!s1_rd && !s1_wr));

  // R2
  wr_cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we) |=> (s1_wr && s1_addr == $past(addr) && s1_mask == $past(bw)));
endmodule

// File: rtl/lw_write_buf.sv
module lw_write_buf #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANES * lw_sram_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_wr,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [LANES-1:0]  s1_mask,
  input  logic [DW-1:0]     wdata,
  output logic              buf_vld,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LANES-1:0]  buf_mask,
  output logic [DW-1:0]     buf_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_addr <= '0;
      buf_mask <= '0;
      buf_data <= '0;
    end else begin
      buf_vld <= s1_wr;
      if (s1_wr) begin
        buf_addr <= s1_addr;
        buf_mask <= s1_mask;
        buf_data <= wdata;
      end
    end
  end

  // R2
  late_data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_wr |=> (buf_vld && buf_data == $past(wdata) && buf_addr == $past(s1_addr)));
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int LW    = lw_sram_pkg::LANE_W,
  localparam int DW    = LANES * LW,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) lane_mem[wr_addr] <= wr_data[g*LW +: LW];
    end
    assign rd_word[g*LW +: LW] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/lw_out_stage.sv
module lw_out_stage #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANES * lw_sram_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_rd,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [DW-1:0]     arr_word,
  input  logic              buf_vld,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [LANES-1:0]  buf_mask,
  input  logic [DW-1:0]     buf_data,
  input  logic              oe,
  output logic              fwd_hit,
  output logic [DW-1:0]     rdata
);
  import lw_sram_pkg::*;

  logic [LANES-1:0]     fwd_lanes;
  logic [MAX_W-1:0]     base_x, upd_x, merged_x;
  logic [MAX_LANES-1:0] en_x;
  logic [DW-1:0]        next_word;
  logic [DW-1:0]        dout_q;

  assign fwd_hit   = s1_rd && buf_vld && (buf_addr == s1_addr);
  assign fwd_lanes = fwd_hit ? buf_mask : '0;

  always_comb begin
    base_x = '0;
    upd_x  = '0;
    en_x   = '0;
    base_x[DW-1:0]  = arr_word;
    upd_x[DW-1:0]   = buf_data;
    en_x[LANES-1:0] = fwd_lanes;
    merged_x  = lane_merge(base_x, upd_x, en_x);
    next_word = merged_x[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dout_q <= '0;
    else if (s1_rd) dout_q <= next_word;
  end

  assign rdata = oe ? dout_q : '0;

  // R5
  fwd_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit && buf_mask == '1) |=> (dout_q == $past(buf_data)));

  // R7
  array_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_rd && !fwd_hit) |=> (dout_q == $past(arr_word)));
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DW    = LANES * lw_sram_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw,
  input  logic [DW-1:0]     wdata,
  input  logic              oe,
  output logic [DW-1:0]     rdata
);
  logic              s1_rd, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic              buf_vld;
  logic [ADDR_W-1:0] buf_addr;
  logic [LANES-1:0]  buf_mask;
  logic [DW-1:0]     buf_data;
  logic [DW-1:0]     arr_word;
  logic              fwd_hit;

  lw_cmd_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .bw(bw),
    .s1_rd(s1_rd), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_mask(s1_mask)
  );

  lw_write_buf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .s1_wr(s1_wr), .s1_addr(s1_addr),
    .s1_mask(s1_mask), .wdata(wdata), .buf_vld(buf_vld),
    .buf_addr(buf_addr), .buf_mask(buf_mask), .buf_data(buf_data)
  );

  lw_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk(clk), .wr_en(buf_vld), .wr_addr(buf_addr), .wr_mask(buf_mask),
    .wr_data(buf_data), .rd_addr(s1_addr), .rd_word(arr_word)
  );

  lw_out_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .s1_rd(s1_rd), .s1_addr(s1_addr),
    .arr_word(arr_word), .buf_vld(buf_vld), .buf_addr(buf_addr),
    .buf_mask(buf_mask), .buf_data(buf_data), .oe(oe),
    .fwd_hit(fwd_hit), .rdata(rdata)
  );
endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
  localparam int AW    = 8;
  localparam int LANES = 4;
  localparam int DW    = 36;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sel, we, oe;
  logic [AW-1:0]    addr;
  logic [LANES-1:0] bw;
  logic [DW-1:0]    wdata, rdata;

  lw_sram #(.ADDR_W(AW), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .bw(bw),
    .wdata(wdata), .oe(oe), .rdata(rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference: a write becomes visible once its data edge passes.
  logic [DW-1:0]    ref_mem [DEPTH];
  bit               m_wr, m_rd;
  int               m_addr;
  logic [LANES-1:0] m_mask;
  logic [DW-1:0]    m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wr = 0; m_rd = 0; m_out = '0;
    end else begin
      if (m_wr)
        for (int i = 0; i < LANES; i++)
          if (m_mask[i]) ref_mem[m_addr][i*9 +: 9] = wdata[i*9 +: 9];
      if (m_rd) m_out = ref_mem[m_addr];
      m_wr = sel && we;
      m_rd = sel && !we;
      m_addr = int'(addr);
      m_mask = bw;
    end
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  logic [DW-1:0] pend_d;

  // One command cycle; wdata carries the previous write's data.
  task automatic op(input logic s, input logic w, input int a,
                    input logic [LANES-1:0] m, input logic [DW-1:0] d);
    sel = s; we = w; addr = AW'(a); bw = m; wdata = pend_d;
    pend_d = (s && w) ? d : rnd_word();
    @(posedge clk);
    @(negedge clk);
    check(cur_req, rdata, oe ? m_out : '0);
  endtask

  task automatic wr(input int a, input logic [LANES-1:0] m, input logic [DW-1:0] d);
    op(1'b1, 1'b1, a, m, d);
  endtask
  task automatic rd(input int a);
    op(1'b1, 1'b0, a, LANES'($urandom()), '0);
  endtask
  task automatic dsel();
    op(1'b0, LANES'($urandom()) != 0, int'($urandom_range(0, DEPTH-1)),
       LANES'($urandom()), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel = 0; we = 0; addr = '0; bw = '0; wdata = '0; oe = 1;
    pend_d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1", rdata, '0);
    dsel();
    check("R1", rdata, '0);

    // R2: fill every word; each data word rides one cycle behind its command
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) wr(a, '1, rnd_word());

    // R3: plain reads, one cycle latency
    cur_req = "R3";
    for (int a = 0; a < 16; a++) rd(a * 7);

    // R5: write then immediate read of the same word, full and partial lanes
    cur_req = "R5";
    wr(3, 4'b1111, 36'h1_2345_6789); rd(3);
    wr(3, 4'b0101, 36'hA_BCDE_F012); rd(3);
    wr(9, 4'b1000, rnd_word());      rd(9);
    dsel();
    check("R5", rdata, m_out);

    // R4: lane masks, including an all-zero mask that writes nothing
    cur_req = "R4";
    wr(20, 4'b1111, 36'h0_0000_0000);
    wr(20, 4'b0010, 36'hF_FFFF_FFFF);
    dsel(); rd(20); dsel();
    check("R4", rdata, 36'h0_0003_FE00);
    wr(20, 4'b0000, 36'hF_FFFF_FFFF); dsel(); rd(20); dsel();
    check("R4", rdata, 36'h0_0003_FE00);

    // R6: back-to-back writes accumulate lanes
    cur_req = "R6";
    wr(40, 4'b0001, 36'h0_0000_0011);
    wr(40, 4'b0100, 36'h0_0440_0000);
    wr(40, 4'b1000, 36'h3_3000_0000);
    rd(40);
    for (int k = 0; k < 4; k++) wr(41, LANES'(1 << k), rnd_word());
    rd(41); rd(40);

    // R7: read followed by write to the same word sees the old value
    cur_req = "R7";
    wr(50, '1, 36'h5_5555_5555); dsel(); dsel();
    rd(50); wr(50, '1, 36'hA_AAAA_AAAA);
    check("R7", rdata, 36'h5_5555_5555);
    rd(50);
    check("R7", rdata, 36'h5_5555_5555);
    dsel();
    check("R7", rdata, 36'hA_AAAA_AAAA);

    // R8: deselect right after a write still commits it
    cur_req = "R8";
    wr(60, '1, 36'h7_0F0F_0F0F); dsel(); dsel(); rd(60); dsel();
    check("R8", rdata, 36'h7_0F0F_0F0F);

    // R9: output holds across write and deselect cycles
    cur_req = "R9";
    rd(3); wr(4, '1, rnd_word()); dsel(); wr(5, 4'b0011, rnd_word()); dsel();
    check("R9", rdata, ref_mem[3]);

    // R10: oe gates the output between edges
    cur_req = "R10";
    #1 oe = 0; #0.5;
    check("R10", rdata, '0);
    #0.5 oe = 1; #0.5;
    check("R10", rdata, ref_mem[3]);
    @(negedge clk);

    // Mixed random traffic over a few words to force collisions
    cur_req = "R5";
    for (int n = 0; n < 3000; n++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      oe = ($urandom_range(0, 7) != 0);
      if (kind < 4)      wr(int'($urandom_range(0, 7)), LANES'($urandom()), rnd_word());
      else if (kind < 8) rd(int'($urandom_range(0, 7)));
      else               dsel();
    end
    oe = 1;
    dsel();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule